// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit carries out the two vector configuration instructions. One takes the requested vector type from an 11-bit immediate in the instruction word. The other takes it from the second source register. Each cycle the unit receives an instruction word, the application vector length (AVL) read from the first source register, and the value of the second source register. From these it decides which form, if any, the word encodes. It then derives the maximum vector length (VLMAX) for the requested element width and register grouping, picks the new vector length, and updates its architectural vector length, vector type and start-index state.

All results are registered. One cycle after a valid instruction is presented, the unit pulses either a completion strobe or a not-decoded strobe. With the completion strobe it presents the value for the destination register and that register's index. The status fields are always available as outputs: the illegal-type flag, the element-width code, the grouping code, and a fast-path flag that says the start index is zero and the length equals VLMAX. A separate write port lets element execution record a resume index in the start-index state.

The sizes are parameters. VLEN is the vector register width in bits: a power of two, at most 4096, default 128. ELEN is the widest element in bits: a power of two no larger than VLEN, default 64. XLEN is the scalar register width, default 32.

Top module: `vcfg_unit`

## Requirements
- R1: A word with bit 31 = 0, bits 14:12 = 111 and bits 6:0 = 1010111 is the immediate form. The requested vtype is bits 30:20, zero-extended, and the rs2 input is ignored.
- R2: A word with bits 31:25 = 1000000, bits 14:12 = 111 and bits 6:0 = 1010111 is the register form. The requested vtype is the full rs2 input.
- R3: For a valid word that matches neither form, the not-decoded strobe pulses one cycle later and vl, vtype and the returned value stay unchanged.
- R4: In vtype, bits 1:0 hold the grouping code lmul and bits 4:2 hold the width code sew, so the element width is 8<<sew bits. VLMAX equals (VLEN<<lmul)>>(3+sew).
- R5: The new vl is VLMAX when AVL is 0 or greater than VLMAX, and AVL otherwise. An rs1 field (bits 19:15) of 0 acts as AVL 0 whatever the AVL input holds.
- R6: A request is illegal when 8<<sew exceeds ELEN or when the top bit of the requested vtype is set. In that case vtype becomes only its top bit (the illegal flag), vl and the returned value become 0, and the start index is left as it was.
- R7: A legal request stores the requested vtype unchanged, sets vl, and clears the start index to 0. The completion strobe pulses one cycle after the instruction, together with the returned value (equal to the new vl) and the destination index from bits 11:7.
- R8: The status outputs are the illegal flag (the top bit of vtype), sew (vtype bits 4:2) and lmul (vtype bits 1:0).
- R9: The fast-path flag is 1 exactly when the start index is 0 and vl equals the VLMAX of the current vtype. It is 0 while the illegal flag is set.
- R10: After reset, vtype holds only the illegal flag, vl is 0, the start index is 0, and both strobes are low.
- R11: The start-index write port loads a new value when no configuration completes in the same cycle. A legal configuration in the same cycle takes priority and clears the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid_i | input | 1 | Instruction word is valid this cycle |
| cfg_instr_i | input | 32 | Instruction word |
| cfg_avl_i | input | XLEN | First source register value (AVL) |
| cfg_rs2_i | input | XLEN | Second source register value |
| vstart_we_i | input | 1 | Start-index write enable |
| vstart_wdata_i | input | clog2(VLEN)+1 | Start-index write data |
| cfg_done_o | output | 1 | Configuration completed (one-cycle pulse) |
| cfg_undecoded_o | output | 1 | Word matched neither form (one-cycle pulse) |
| rd_value_o | output | XLEN | Value for the destination register |
| rd_idx_o | output | 5 | Destination register index |
| vl_o | output | clog2(VLEN)+1 | Current vector length |
| vstart_o | output | clog2(VLEN)+1 | Current start index |
| vtype_o | output | XLEN | Current vector type |
| vill_o | output | 1 | Illegal-type flag |
| sew_o | output | 3 | Element-width code |
| lmul_o | output | 2 | Grouping code |
| vl_is_max_o | output | 1 | Start index is 0 and vl equals VLMAX |

## Verification
The bench runs every lmul and sew code through both instruction forms with AVL set to 0, 1, VLMAX-1, VLMAX, VLMAX+1 and all ones. It computes VLMAX and the expected vl arithmetically. A wrong shift amount would give VLMAX off by a power of two. An off-by-one bound would cap at VLMAX-1 or pass VLMAX+1 through. A missing zero test would return 0 instead of VLMAX. The width codes just above ELEN must leave only the illegal flag, vl 0, and an untouched start index; a design that cleared the index or kept the old vl would show up there. The bench also covers:
- words that are near misses in one decode field, which must change no state;
- an rs1 field of zero with a non-zero AVL input;
- a start-index write in the same cycle as a configuration;
- a non-zero start index, which must hold the fast-path flag low even when vl equals VLMAX.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

  // Instruction fields shared by both configuration forms
  localparam logic [6:0] OP_VECTOR   = 7'b1010111;
  localparam logic [2:0] F3_CONFIG   = 3'b111;
  localparam logic [6:0] F7_REG_FORM = 7'b1000000;

  typedef enum logic [1:0] {
    FORM_NONE = 2'd0,
    FORM_IMM  = 2'd1,
    FORM_REG  = 2'd2
  } cfg_form_e;

  typedef struct packed {
    cfg_form_e   form;
    logic [4:0]  rd;
    logic [4:0]  rs1;
    logic [10:0] zimm;
  } cfg_dec_t;

endpackage

// File: rtl/vcfg_decode.sv
module vcfg_decode
  import vcfg_pkg::*;
(
  input  logic [31:0] instr_i,
  output cfg_dec_t    dec_o
);

  logic common_ok;
  logic imm_hit;
  logic reg_hit;

  always_comb begin
    common_ok = (instr_i[6:0] == OP_VECTOR) && (instr_i[14:12] == F3_CONFIG);
    imm_hit   = common_ok && !instr_i[31];
    reg_hit   = common_ok && (instr_i[31:25] == F7_REG_FORM);
    dec_o.rd   = instr_i[11:7];
    dec_o.rs1  = instr_i[19:15];
    dec_o.zimm = instr_i[30:20];
    if (imm_hit)      dec_o.form = FORM_IMM;
    else if (reg_hit) dec_o.form = FORM_REG;
    else              dec_o.form = FORM_NONE;
  end

endmodule

// File: rtl/vcfg_vlmax.sv
module vcfg_vlmax #(
  parameter int VLEN = 128,
  parameter int ELEN = 64,
  localparam int VL_W = $clog2(VLEN) + 1
) (
  input  logic [2:0]      sew_i,
  input  logic [1:0]      lmul_i,
  input  logic            top_bit_i,
  output logic            legal_o,
  output logic [VL_W-1:0] vlmax_o
);

  localparam int PW = $clog2(VLEN) + 4;

  logic [7:0]    width_ok;
  logic [PW-1:0] scaled;
  logic [PW-1:0] shifted;
  logic [3:0]    shamt;

  // one legality bit per width code, fixed at elaboration
  for (genvar g = 0; g < 8; g++) begin : g_width
    localparam int WBITS = 8 << g;
    assign width_ok[g] = (WBITS <= ELEN);
  end

  always_comb begin
    shamt   = {1'b0, sew_i} + 4'd3;
    scaled  = PW'(VLEN) << lmul_i;
    shifted = scaled >> shamt;
    vlmax_o = shifted[VL_W-1:0];
    legal_o = width_ok[sew_i] && !top_bit_i;
  end

endmodule

// File: rtl/vcfg_vlsel.sv
module vcfg_vlsel #(
  parameter int XLEN = 32,
  parameter int VL_W = 8
) (
  input  logic [XLEN-1:0] avl_i,
  input  logic            rs1_zero_i,
  input  logic [VL_W-1:0] vlmax_i,
  input  logic            legal_i,
  output logic [VL_W-1:0] vl_o
);

  logic take_max;

  always_comb begin
    take_max = rs1_zero_i || (avl_i == '0) || (avl_i > XLEN'(vlmax_i));
    if (!legal_i)      vl_o = '0;
    else if (take_max) vl_o = vlmax_i;
    else               vl_o = avl_i[VL_W-1:0];
  end

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
  import vcfg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int VLEN = 128,
  parameter int ELEN = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_valid_i,
  input  logic [31:0]            cfg_instr_i,
  input  logic [XLEN-1:0]        cfg_avl_i,
  input  logic [XLEN-1:0]        cfg_rs2_i,
  input  logic                   vstart_we_i,
  input  logic [$clog2(VLEN):0]  vstart_wdata_i,
  output logic                   cfg_done_o,
  output logic                   cfg_undecoded_o,
  output logic [XLEN-1:0]        rd_value_o,
  output logic [4:0]             rd_idx_o,
  output logic [$clog2(VLEN):0]  vl_o,
  output logic [$clog2(VLEN):0]  vstart_o,
  output logic [XLEN-1:0]        vtype_o,
  output logic                   vill_o,
  output logic [2:0]             sew_o,
  output logic [1:0]             lmul_o,
  output logic                   vl_is_max_o
);

  localparam int VL_W = $clog2(VLEN) + 1;
  localparam logic [XLEN-1:0] VTYPE_ILL = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [VL_W-1:0] RST_VLMAX = VL_W'(VLEN / 8);

  cfg_dec_t        dec;
  logic [XLEN-1:0] vtype_req;
  logic            req_legal;
  logic [VL_W-1:0] req_vlmax;
  logic [VL_W-1:0] new_vl;
  logic            go;

  logic [VL_W-1:0] vl_q, vstart_q, vlmax_q;
  logic [XLEN-1:0] vtype_q, rd_q;
  logic [4:0]      rd_idx_q;
  logic            done_q, undec_q;

  vcfg_decode u_dec (
    .instr_i (cfg_instr_i),
    .dec_o   (dec)
  );

  always_comb begin
    vtype_req = (dec.form == FORM_IMM) ? XLEN'(dec.zimm) : cfg_rs2_i;
    go        = cfg_valid_i && (dec.form != FORM_NONE);
  end

  vcfg_vlmax #(.VLEN(VLEN), .ELEN(ELEN)) u_vlmax (
    .sew_i     (vtype_req[4:2]),
    .lmul_i    (vtype_req[1:0]),
    .top_bit_i (vtype_req[XLEN-1]),
    .legal_o   (req_legal),
    .vlmax_o   (req_vlmax)
  );

  vcfg_vlsel #(.XLEN(XLEN), .VL_W(VL_W)) u_vlsel (
    .avl_i      (cfg_avl_i),
    .rs1_zero_i (dec.rs1 == 5'd0),
    .vlmax_i    (req_vlmax),
    .legal_i    (req_legal),
    .vl_o       (new_vl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vl_q     <= '0;
      vstart_q <= '0;
      vlmax_q  <= RST_VLMAX;
      vtype_q  <= VTYPE_ILL;
      rd_q     <= '0;
      rd_idx_q <= '0;
      done_q   <= 1'b0;
      undec_q  <= 1'b0;
    end else begin
      done_q  <= go;
      undec_q <= cfg_valid_i && (dec.form == FORM_NONE);
      if (go) begin
        vl_q     <= new_vl;
        vlmax_q  <= req_vlmax;
        vtype_q  <= req_legal ? vtype_req : VTYPE_ILL;
        rd_q     <= XLEN'(new_vl);
        rd_idx_q <= dec.rd;
      end
      // a legal configuration restarts element indexing
      if (go && req_legal)   vstart_q <= '0;
      else if (vstart_we_i)  vstart_q <= vstart_wdata_i;
    end
  end

  always_comb begin
    cfg_done_o      = done_q;
    cfg_undecoded_o = undec_q;
    rd_value_o      = rd_q;
    rd_idx_o        = rd_idx_q;
    vl_o            = vl_q;
    vstart_o        = vstart_q;
    vtype_o         = vtype_q;
    vill_o          = vtype_q[XLEN-1];
    sew_o           = vtype_q[4:2];
    lmul_o          = vtype_q[1:0];
    vl_is_max_o     = !vtype_q[XLEN-1] && (vstart_q == '0) && (vl_q == vlmax_q);
  end

  // R3: an undecoded word leaves the length and type untouched
  a_r3_undecoded_holds: assert property (@(posedge clk) disable iff (rst)
    undec_q |-> ($stable(vl_q) && $stable(vtype_q) && $stable(rd_q)));

  // R3 and R7: at most one strobe per cycle
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_q, undec_q}));

  // R5: a legal length never exceeds the cap of its type
  a_r5_vl_capped: assert property (@(posedge clk) disable iff (rst)
    !vtype_q[XLEN-1] |-> (vl_q <= vlmax_q));

  // R6: the illegal state always carries a zero length
  a_r6_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    vtype_q[XLEN-1] |-> (vl_q == '0));

  // R7: the returned value matches the stored length on completion
  a_r7_rd_matches: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (rd_q == XLEN'(vl_q)));

  // R7: a legal completion leaves the start index cleared
  a_r7_vstart_clear: assert property (@(posedge clk) disable iff (rst)
    (done_q && !vtype_q[XLEN-1]) |-> (vstart_q == '0));

endmodule

// File: tb/vcfg_unit_test.sv
`timescale 1ns/1ps
module vcfg_unit_test;

  localparam int XLEN = 32;
  localparam int VLEN = 128;
  localparam int ELEN = 64;
  localparam int VL_W = $clog2(VLEN) + 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cfg_valid_i = 1'b0;
  logic [31:0]     cfg_instr_i = '0;
  logic [XLEN-1:0] cfg_avl_i = '0;
  logic [XLEN-1:0] cfg_rs2_i = '0;
  logic            vstart_we_i = 1'b0;
  logic [VL_W-1:0] vstart_wdata_i = '0;
  logic            cfg_done_o, cfg_undecoded_o, vill_o, vl_is_max_o;
  logic [XLEN-1:0] rd_value_o, vtype_o;
  logic [4:0]      rd_idx_o;
  logic [VL_W-1:0] vl_o, vstart_o;
  logic [2:0]      sew_o;
  logic [1:0]      lmul_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN), .ELEN(ELEN)) uut (
    .clk, .rst, .cfg_valid_i, .cfg_instr_i, .cfg_avl_i, .cfg_rs2_i,
    .vstart_we_i, .vstart_wdata_i, .cfg_done_o, .cfg_undecoded_o,
    .rd_value_o, .rd_idx_o, .vl_o, .vstart_o, .vtype_o, .vill_o,
    .sew_o, .lmul_o, .vl_is_max_o
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] w_imm(input logic [10:0] zimm, input logic [4:0] rs1, input logic [4:0] rd);
    return {1'b0, zimm, rs1, 3'b111, rd, 7'b1010111};
  endfunction

  function automatic logic [31:0] w_reg(input logic [4:0] rs1, input logic [4:0] rd);
    return {7'b1000000, 5'd3, rs1, 3'b111, rd, 7'b1010111};
  endfunction

  // drive one word at the falling edge, sample at the next falling edge
  task automatic issue(input logic [31:0] w, input logic [XLEN-1:0] avl, input logic [XLEN-1:0] rs2);
    @(negedge clk);
    cfg_valid_i = 1'b1;
    cfg_instr_i = w;
    cfg_avl_i   = avl;
    cfg_rs2_i   = rs2;
    @(negedge clk);
    cfg_valid_i = 1'b0;
  endtask

  task automatic write_vstart(input int v);
    @(negedge clk);
    vstart_we_i = 1'b1;
    vstart_wdata_i = VL_W'(v);
    @(negedge clk);
    vstart_we_i = 1'b0;
  endtask

  // check full state after a configuration, from the requirement arithmetic
  task automatic expect_cfg(input logic [XLEN-1:0] req, input longint avl, input bit rs1_zero,
                            input int old_vstart, input string tag);
    int sew = int'(req[4:2]);
    int lmul = int'(req[1:0]);
    bit legal = ((8 << sew) <= ELEN) && !req[XLEN-1];
    longint vmax = (longint'(VLEN) << lmul) >> (3 + sew);
    longint evl = (!legal) ? 0 : ((rs1_zero || avl == 0 || avl > vmax) ? vmax : avl);
    logic [XLEN-1:0] evt = legal ? req : {1'b1, {(XLEN-1){1'b0}}};
    int evs = legal ? 0 : old_vstart;
    chk(cfg_done_o == 1'b1, {tag, " R7 done"}, cfg_done_o, 1);
    chk(cfg_undecoded_o == 1'b0, {tag, " R7 undecoded low"}, cfg_undecoded_o, 0);
    chk(vl_o == VL_W'(evl), {tag, " R5 vl"}, vl_o, evl);
    chk(rd_value_o == XLEN'(evl), {tag, " R7 rd value"}, rd_value_o, evl);
    chk(vtype_o == evt, {tag, " R6 vtype"}, vtype_o, evt);
    chk(int'(vstart_o) == evs, {tag, " R6 vstart"}, vstart_o, evs);
    chk(vill_o == !legal, {tag, " R8 vill"}, vill_o, !legal);
    chk(sew_o == evt[4:2] && lmul_o == evt[1:0], {tag, " R8 fields"}, {sew_o, lmul_o}, {evt[4:2], evt[1:0]});
    chk(vl_is_max_o == (legal && evl == vmax && evs == 0), {tag, " R9 flag"},
        vl_is_max_o, (legal && evl == vmax));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected below 100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [XLEN-1:0] saved_vt;
    logic [VL_W-1:0] saved_vl;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(vtype_o == 32'h8000_0000, "R10 vtype", vtype_o, 32'h8000_0000);
    chk(vl_o == 0 && vstart_o == 0, "R10 vl vstart", {vl_o, vstart_o}, 0);
    chk(!cfg_done_o && !cfg_undecoded_o, "R10 strobes", {cfg_done_o, cfg_undecoded_o}, 0);
    chk(vill_o && !vl_is_max_o, "R10 vill flag", {vill_o, vl_is_max_o}, 2'b10);

    // R1 R2 R4 R5 R6 sweep over every type code and both forms
    for (int lm = 0; lm < 4; lm++) begin
      for (int sw = 0; sw < 8; sw++) begin
        longint vmax = (longint'(VLEN) << lm) >> (3 + sw);
        longint avls[6] = '{0, 1, vmax - 1, vmax, vmax + 1, 64'hFFFF_FFFF};
        for (int k = 0; k < 6; k++) begin
          logic [XLEN-1:0] req = XLEN'((sw << 2) | lm);
          longint a = (avls[k] < 0) ? 0 : avls[k];
          int vs_before = int'(vstart_o);
          if (k % 2 == 0) begin
            issue(w_imm(req[10:0], 5'd1, 5'd2), XLEN'(a), 32'hDEAD_BEEF);
            expect_cfg(req, a, 1'b0, vs_before, "R1 imm");
          end else begin
            issue(w_reg(5'd1, 5'd2), XLEN'(a), req);
            expect_cfg(req, a, 1'b0, vs_before, "R2 reg");
          end
          chk(rd_idx_o == 5'd2, "R7 rd index", rd_idx_o, 2);
        end
      end
    end

    // R1 reserved bits of the immediate are stored as given
    issue(w_imm(11'h4C5, 5'd1, 5'd9), 32'd3, 32'h0);
    expect_cfg(32'h0000_04C5, 3, 1'b0, 0, "R1 reserved");
    chk(rd_idx_o == 5'd9, "R7 rd index 9", rd_idx_o, 9);

    // R5 rs1 field zero forces the cap
    issue(w_imm(11'h001, 5'd0, 5'd2), 32'd5, 32'h0);
    expect_cfg(32'h0000_0001, 5, 1'b1, 0, "R5 rs1 zero");

    // R9 nonzero start index holds the flag low
    issue(w_imm(11'h000, 5'd1, 5'd2), 32'd0, 32'h0);
    chk(vl_is_max_o == 1'b1, "R9 flag set", vl_is_max_o, 1);
    write_vstart(5);
    chk(vstart_o == 5, "R11 vstart written", vstart_o, 5);
    chk(vl_is_max_o == 1'b0, "R9 flag low on vstart", vl_is_max_o, 0);

    // R6 illegal width keeps the start index
    issue(w_imm(11'h010, 5'd1, 5'd2), 32'd4, 32'h0);
    expect_cfg(32'h0000_0010, 4, 1'b0, 5, "R6 wide sew");

    // R6 top bit in the register form is illegal
    issue(w_reg(5'd1, 5'd2), 32'd4, 32'h8000_0001);
    expect_cfg(32'h8000_0001, 4, 1'b0, 5, "R6 top bit");

    // R11 config and start-index write in the same cycle: config clears
    @(negedge clk);
    cfg_valid_i = 1'b1;
    cfg_instr_i = w_imm(11'h005, 5'd1, 5'd2);
    cfg_avl_i = 32'd7;
    vstart_we_i = 1'b1;
    vstart_wdata_i = VL_W'(9);
    @(negedge clk);
    cfg_valid_i = 1'b0;
    vstart_we_i = 1'b0;
    chk(vstart_o == 0, "R11 config wins", vstart_o, 0);
    chk(vl_o == 7, "R11 vl", vl_o, 7);

    // R3 near-miss words change nothing
    saved_vt = vtype_o;
    saved_vl = vl_o;
    for (int m = 0; m < 4; m++) begin
      logic [31:0] w = w_reg(5'd1, 5'd2);
      if (m == 0) w[6:0] = 7'b1010110;
      if (m == 1) w[14:12] = 3'b110;
      if (m == 2) w[31:25] = 7'b1100000;
      if (m == 3) w[31:25] = 7'b1000001;
      issue(w, 32'd1, 32'h0000_0003);
      chk(cfg_undecoded_o == 1'b1 && cfg_done_o == 1'b0, "R3 strobe",
          {cfg_undecoded_o, cfg_done_o}, 2'b10);
      chk(vtype_o == saved_vt && vl_o == saved_vl, "R3 state held",
          {vtype_o, vl_o}, {saved_vt, saved_vl});
    end
    @(negedge clk);
    chk(!cfg_undecoded_o && !cfg_done_o, "R3 strobe is a pulse", {cfg_undecoded_o, cfg_done_o}, 0);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule